// File: doc/BRIEF.md
# High-Speed Chirp Handshake Controller (Device Side)

This block runs on the peripheral side of a USB link layer. It moves the link from full-speed to high-speed signalling while a bus reset is in progress. When the transceiver reports a reset, the controller waits a set delay and then asks the transmitter to send its own Chirp K for a set length. After that it watches the two-bit line state for the host's answer. The answer is a run of alternating K and J chirps, and each chirp must be held steady for a debounce time before it counts.

When enough properly alternating chirps have been counted, the controller switches termination and operating mode to the high-speed setting. It then waits for the line to report squelch, which means the host has stopped chirping and packet traffic will follow. At that point it raises a high-speed-ready flag. If the reset ends before the handshake reaches high-speed mode, a full-speed fallback flag is raised instead. Either flag holds until the next reset starts.

All times are clock counts set by parameters. At 60 MHz the debounce is 150 cycles, which is 2.5 µs.

Top module: `hs_chirp_ctrl`

## Requirements
- R1: After `rst_n` is released with `busResetDet` low, the outputs are `termSel`=1, `opMode`=00, and `txChirpReq`, `hsReady` and `fsFallback` are all 0.
- R2: On the first clock edge that samples `busResetDet` high in idle, a handshake starts. `txChirpReq` rises TX_DELAY+1 cycles later and stays high for exactly CHIRP_LEN cycles. From the start of the handshake until high-speed entry, `termSel`=1 and `opMode`=10.
- R3: Line state codes are 00 for SE0, 01 for J and 10 for K. A host chirp symbol is accepted only on the DEBOUNCE-th consecutive cycle of an unchanged line state, and it is accepted once per run.
- R4: Host chirps are counted only after the device's own Chirp K has ended. The counted sequence must start with K and alternate K, J, K, and so on. The clock edge that accepts the MIN_CHIRPS-th symbol sets `termSel`=0 and `opMode`=00.
- R5: A run that changes before it reaches DEBOUNCE cycles neither advances nor clears the chirp count.
- R6: An accepted K or J that does not match the symbol expected next clears the count to zero.
- R7: In high-speed wait, line state 01 (not squelched) does not raise `hsReady`. Line state 10 (squelch) held for DEBOUNCE cycles raises `hsReady` on the edge that accepts it.
- R8: If `busResetDet` falls before high-speed entry (during the delay, the device chirp or the host chirp count), `fsFallback` rises on the next edge, `txChirpReq` drops, and `termSel`=1 and `opMode`=00.
- R9: `hsReady` and `fsFallback` hold through a fall of `busResetDet`. A new rising edge of `busResetDet` clears them and restarts the handshake from R2.
- R10: `txChirpReq` is never high DEADLINE or more cycles after the reset that started the handshake, and it is never high for more than CHIRP_LEN cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 60 MHz link clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busResetDet | input | 1 | High while the transceiver reports a bus reset |
| lineState | input | 2 | Line state from the transceiver (00 SE0, 01 J / not squelched, 10 K / squelch) |
| txChirpReq | output | 1 | Request to transmit the device Chirp K |
| termSel | output | 1 | Termination select: 1 full-speed, 0 high-speed |
| opMode | output | 2 | Operating mode: 00 normal, 10 chirp mode (no bit stuff, no NRZI) |
| hsReady | output | 1 | Host chirp finished; high-speed traffic may begin |
| fsFallback | output | 1 | Reset ended without a valid host chirp; stay at full speed |

## Verification
Several host chirp streams are driven into the controller:
- A clean K-J run of the minimum length checks that the switch to high-speed happens on exactly the cycle the last symbol is accepted.
- A run whose final symbol is cut short, then followed by SE0, shows that a short run is dropped without losing the count.
- A stream with a repeated K and a leading J shows that a broken alternation restarts the count. Without the restart, a fault would switch modes early.
- In high-speed wait, long not-squelched periods and a squelch pulse shorter than the debounce are applied before a real squelch. This checks that only a held squelch sets the ready flag.
- Dropping the reset during the delay, during the device chirp and partway through the host count checks each fallback path.
- Re-raising the reset from the ready state checks that the handshake restarts.

// File: rtl/hs_chirp_pkg.sv
package hs_chirp_pkg;

  localparam logic [1:0] LS_SE0 = 2'b00;
  localparam logic [1:0] LS_J   = 2'b01;
  localparam logic [1:0] LS_K   = 2'b10;
  localparam logic [1:0] LS_SQUELCH = 2'b10;

  localparam logic [1:0] OPM_NORMAL = 2'b00;
  localparam logic [1:0] OPM_CHIRP  = 2'b10;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DELAY,
    ST_DEV_CHIRP,
    ST_HOST_COUNT,
    ST_SQUELCH_WAIT,
    ST_HS_READY,
    ST_FS_FALLBACK
  } chirpState_t;

  typedef struct packed {
    logic timerClr;
    logic seqInc;
    logic seqClr;
  } dpCtl_t;

endpackage

// File: rtl/hs_chirp_dp.sv
module hs_chirp_dp
  import hs_chirp_pkg::*;
#(
  parameter int DEBOUNCE = 150,
  parameter int TIMER_W  = 17,
  parameter int SEQ_W    = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         lineState,
  input  dpCtl_t             ctl,
  output logic [TIMER_W-1:0] timer,
  output logic [SEQ_W-1:0]   seqCount,
  output logic               qualValid,
  output logic [1:0]         qualSym
);

  localparam int RUN_W = $clog2(DEBOUNCE + 1);
  localparam logic [RUN_W-1:0] RUN_HIT = RUN_W'(DEBOUNCE - 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(DEBOUNCE);

  logic [1:0]       runSym;
  logic [RUN_W-1:0] runCnt;

  // Length of the current unchanged line-state run, saturating at DEBOUNCE
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      runSym <= LS_SE0;
      runCnt <= '0;
    end else if (lineState != runSym) begin
      runSym <= lineState;
      runCnt <= RUN_W'(1);
    end else if (runCnt != RUN_MAX) begin
      runCnt <= runCnt + RUN_W'(1);
    end
  end

  // Single pulse on the DEBOUNCE-th cycle of a steady run
  assign qualValid = (lineState == runSym) && (runCnt == RUN_HIT);
  assign qualSym   = runSym;

  // Phase timer, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timer <= '0;
    end else if (ctl.timerClr) begin
      timer <= '0;
    end else if (timer != '1) begin
      timer <= timer + TIMER_W'(1);
    end
  end

  // Count of accepted, correctly alternating host chirps
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seqCount <= '0;
    end else if (ctl.seqClr) begin
      seqCount <= '0;
    end else if (ctl.seqInc) begin
      seqCount <= seqCount + SEQ_W'(1);
    end
  end

endmodule

// File: rtl/hs_chirp_fsm.sv
module hs_chirp_fsm
  import hs_chirp_pkg::*;
#(
  parameter int TX_DELAY   = 6000,
  parameter int CHIRP_LEN  = 66000,
  parameter int MIN_CHIRPS = 6,
  parameter int TIMER_W    = 17,
  parameter int SEQ_W      = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               busResetDet,
  input  logic [TIMER_W-1:0] timer,
  input  logic [SEQ_W-1:0]   seqCount,
  input  logic               qualValid,
  input  logic [1:0]         qualSym,
  output dpCtl_t             ctl,
  output logic               txChirpReq,
  output logic               termSel,
  output logic [1:0]         opMode,
  output logic               hsReady,
  output logic               fsFallback
);

  localparam logic [TIMER_W-1:0] DELAY_END = TIMER_W'(TX_DELAY - 1);
  localparam logic [TIMER_W-1:0] CHIRP_END = TIMER_W'(CHIRP_LEN - 1);
  localparam logic [SEQ_W-1:0]   SEQ_LAST  = SEQ_W'(MIN_CHIRPS - 1);

  chirpState_t state, stateNext;
  logic        resetPrev;
  logic        resetRise;
  logic [1:0]  expectSym;
  logic        symIsChirp;

  assign resetRise  = busResetDet && !resetPrev;
  assign expectSym  = seqCount[0] ? LS_J : LS_K;
  assign symIsChirp = (qualSym == LS_J) || (qualSym == LS_K);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      resetPrev <= 1'b0;
    end else begin
      state     <= stateNext;
      resetPrev <= busResetDet;
    end
  end

  always_comb begin
    stateNext = state;
    ctl       = '0;
    unique case (state)
      ST_IDLE: begin
        if (busResetDet) begin
          stateNext    = ST_DELAY;
          ctl.timerClr = 1'b1;
          ctl.seqClr   = 1'b1;
        end
      end
      ST_DELAY: begin
        if (!busResetDet) begin
          stateNext = ST_FS_FALLBACK;
        end else if (timer == DELAY_END) begin
          stateNext    = ST_DEV_CHIRP;
          ctl.timerClr = 1'b1;
        end
      end
      ST_DEV_CHIRP: begin
        if (!busResetDet) begin
          stateNext = ST_FS_FALLBACK;
        end else if (timer == CHIRP_END) begin
          stateNext  = ST_HOST_COUNT;
          ctl.seqClr = 1'b1;
        end
      end
      ST_HOST_COUNT: begin
        if (!busResetDet) begin
          stateNext = ST_FS_FALLBACK;
        end else if (qualValid && symIsChirp) begin
          if (qualSym == expectSym) begin
            ctl.seqInc = 1'b1;
            if (seqCount == SEQ_LAST) stateNext = ST_SQUELCH_WAIT;
          end else begin
            ctl.seqClr = 1'b1;
          end
        end
      end
      ST_SQUELCH_WAIT: begin
        if (qualValid && qualSym == LS_SQUELCH) stateNext = ST_HS_READY;
      end
      ST_HS_READY, ST_FS_FALLBACK: begin
        if (resetRise) begin
          stateNext    = ST_DELAY;
          ctl.timerClr = 1'b1;
          ctl.seqClr   = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign txChirpReq = (state == ST_DEV_CHIRP);
  assign termSel    = !((state == ST_SQUELCH_WAIT) || (state == ST_HS_READY));
  assign opMode     = ((state == ST_DELAY) || (state == ST_DEV_CHIRP) ||
                       (state == ST_HOST_COUNT)) ? OPM_CHIRP : OPM_NORMAL;
  assign hsReady    = (state == ST_HS_READY);
  assign fsFallback = (state == ST_FS_FALLBACK);

endmodule

// File: rtl/hs_chirp_ctrl.sv
module hs_chirp_ctrl
  import hs_chirp_pkg::*;
#(
  parameter int DEBOUNCE   = 150,
  parameter int TX_DELAY   = 6000,
  parameter int CHIRP_LEN  = 66000,
  parameter int MIN_CHIRPS = 6,
  parameter int DEADLINE   = 420000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       busResetDet,
  input  logic [1:0] lineState,
  output logic       txChirpReq,
  output logic       termSel,
  output logic [1:0] opMode,
  output logic       hsReady,
  output logic       fsFallback
);

  localparam int TIMER_MAX = (TX_DELAY > CHIRP_LEN) ? TX_DELAY : CHIRP_LEN;
  localparam int TIMER_W   = $clog2(TIMER_MAX + 1);
  localparam int SEQ_W     = $clog2(MIN_CHIRPS + 1);

  dpCtl_t             ctl;
  logic [TIMER_W-1:0] timer;
  logic [SEQ_W-1:0]   seqCount;
  logic               qualValid;
  logic [1:0]         qualSym;

  hs_chirp_dp #(
    .DEBOUNCE(DEBOUNCE),
    .TIMER_W (TIMER_W),
    .SEQ_W   (SEQ_W)
  ) i_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .lineState(lineState),
    .ctl      (ctl),
    .timer    (timer),
    .seqCount (seqCount),
    .qualValid(qualValid),
    .qualSym  (qualSym)
  );

  hs_chirp_fsm #(
    .TX_DELAY  (TX_DELAY),
    .CHIRP_LEN (CHIRP_LEN),
    .MIN_CHIRPS(MIN_CHIRPS),
    .TIMER_W   (TIMER_W),
    .SEQ_W     (SEQ_W)
  ) i_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .busResetDet(busResetDet),
    .timer      (timer),
    .seqCount   (seqCount),
    .qualValid  (qualValid),
    .qualSym    (qualSym),
    .ctl        (ctl),
    .txChirpReq (txChirpReq),
    .termSel    (termSel),
    .opMode     (opMode),
    .hsReady    (hsReady),
    .fsFallback (fsFallback)
  );

endmodule

// File: rtl/hs_chirp_chk.sv
module hs_chirp_chk #(
  parameter int CHIRP_LEN = 66000,
  parameter int DEADLINE  = 420000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       busResetDet,
  input logic [1:0] lineState,
  input logic       txChirpReq,
  input logic       termSel,
  input logic [1:0] opMode,
  input logic       hsReady,
  input logic       fsFallback
);

  logic        rstSeen;
  logic [31:0] sinceReset;
  logic [31:0] chirpRun;

  // Cycles since the latest rising edge of the bus reset, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rstSeen    <= 1'b0;
      sinceReset <= '0;
    end else begin
      rstSeen <= busResetDet;
      if (busResetDet && !rstSeen) sinceReset <= '0;
      else if (sinceReset != '1)   sinceReset <= sinceReset + 32'd1;
    end
  end

  // Consecutive cycles the chirp request has already been high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          chirpRun <= '0;
    else if (txChirpReq) chirpRun <= chirpRun + 32'd1;
    else                 chirpRun <= '0;
  end

  AST_CHIRP_DEADLINE: assert property (@(posedge clk) disable iff (!rst_n)
    txChirpReq |-> (sinceReset < 32'(DEADLINE))) else $error("chirp past deadline"); // R10

  AST_CHIRP_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    txChirpReq |-> (chirpRun < 32'(CHIRP_LEN))) else $error("chirp too long"); // R10

  AST_CHIRP_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    txChirpReq |-> (termSel && opMode == 2'b10)) else $error("chirp outside chirp mode"); // R2

  AST_HS_SETTINGS: assert property (@(posedge clk) disable iff (!rst_n)
    hsReady |-> (!termSel && opMode == 2'b00)) else $error("ready without hs settings"); // R4

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(hsReady && fsFallback)) else $error("both flags set"); // R9

  AST_READY_ON_SQUELCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hsReady) |-> ($past(lineState) == 2'b10 && !$past(termSel))) else $error("ready without squelch"); // R7

  AST_FALLBACK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fsFallback) |-> !$past(busResetDet)) else $error("fallback while reset held"); // R8

endmodule

bind hs_chirp_ctrl hs_chirp_chk #(
  .CHIRP_LEN(CHIRP_LEN),
  .DEADLINE (DEADLINE)
) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busResetDet(busResetDet),
  .lineState  (lineState),
  .txChirpReq (txChirpReq),
  .termSel    (termSel),
  .opMode     (opMode),
  .hsReady    (hsReady),
  .fsFallback (fsFallback)
);

// File: tb/test_hs_chirp_ctrl.sv
module test_hs_chirp_ctrl;

  localparam int DEB  = 8;
  localparam int TD   = 20;
  localparam int CL   = 40;
  localparam int MINC = 6;
  localparam int DL   = 100;
  localparam int HOLD = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       busResetDet = 1'b0;
  logic [1:0] lineState = 2'b00;
  logic       txChirpReq, termSel, hsReady, fsFallback;
  logic [1:0] opMode;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  hs_chirp_ctrl #(
    .DEBOUNCE(DEB), .TX_DELAY(TD), .CHIRP_LEN(CL),
    .MIN_CHIRPS(MINC), .DEADLINE(DL)
  ) i_hs_chirp_ctrl (
    .clk(clk), .rst_n(rst_n), .busResetDet(busResetDet), .lineState(lineState),
    .txChirpReq(txChirpReq), .termSel(termSel), .opMode(opMode),
    .hsReady(hsReady), .fsFallback(fsFallback)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // outputs packed: {txChirpReq, termSel, opMode, hsReady, fsFallback}
  function automatic int outs();
    return {txChirpReq, termSel, opMode, hsReady, fsFallback};
  endfunction

  task automatic hardReset();
    @(negedge clk);
    rst_n = 1'b0; busResetDet = 1'b0; lineState = 2'b00;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic drive(input logic [1:0] sym, input int n);
    lineState = sym;
    repeat (n) @(negedge clk);
  endtask

  // start a bus reset and wait until host chirp counting is active
  task automatic toHostCount();
    busResetDet = 1'b1;
    repeat (TD + CL + 2) @(negedge clk);
  endtask

  task automatic t_reset_state();
    hardReset();
    chk("R1 idle outputs", outs(), 6'b010000);
  endtask

  task automatic t_chirp_timing();
    int k;
    int len;
    hardReset();
    busResetDet = 1'b1;
    k = 0;
    do begin
      @(negedge clk); k++;
      if (k == 1) chk("R2 chirp mode at start", {termSel, opMode}, 3'b110);
    end while (!txChirpReq && k < 500);
    chk("R2 chirp start delay", k, TD + 1);
    chk("R2 mode during chirp", {termSel, opMode}, 3'b110);
    len = 0;
    while (txChirpReq && len < 500) begin
      len++; @(negedge clk);
    end
    chk("R2 chirp length", len, CL);
    chk("R4 mode after own chirp", {termSel, opMode}, 3'b110);
  endtask

  task automatic t_good_sequence();
    hardReset();
    toHostCount();
    for (int i = 0; i < MINC - 1; i++) drive((i % 2 == 0) ? 2'b10 : 2'b01, HOLD);
    chk("R4 still full speed after 5 chirps", termSel, 1);
    drive(2'b01, DEB - 1);
    chk("R3 one cycle before debounce", termSel, 1);
    @(negedge clk);
    chk("R4 hs entry termSel/opMode", {termSel, opMode}, 3'b000);
    chk("R7 not ready right after entry", hsReady, 0);
  endtask

  task automatic t_squelch();
    drive(2'b01, 30);
    chk("R7 not ready while not squelched", hsReady, 0);
    drive(2'b10, DEB - 2);
    drive(2'b01, 4);
    chk("R7 short squelch ignored", hsReady, 0);
    drive(2'b10, DEB - 1);
    chk("R7 ready one cycle before debounce", hsReady, 0);
    @(negedge clk);
    chk("R7 ready on held squelch", {hsReady, fsFallback}, 2'b10);
  endtask

  task automatic t_ready_restart();
    busResetDet = 1'b0;
    repeat (10) @(negedge clk);
    chk("R9 ready holds after reset end", {hsReady, termSel}, 2'b10);
    busResetDet = 1'b1;
    @(negedge clk);
    chk("R9 new reset clears ready", {hsReady, termSel, opMode}, 4'b0110);
    repeat (TD) @(negedge clk);
    chk("R9 restarted chirp", txChirpReq, 1);
  endtask

  task automatic t_short_run();
    hardReset();
    toHostCount();
    for (int i = 0; i < MINC - 1; i++) drive((i % 2 == 0) ? 2'b10 : 2'b01, HOLD);
    drive(2'b01, DEB - 2);
    drive(2'b00, 4);
    chk("R5 short run does not count", termSel, 1);
    drive(2'b01, DEB);
    chk("R5 count kept after short run", {termSel, opMode}, 3'b000);
  endtask

  task automatic t_bad_order();
    hardReset();
    toHostCount();
    drive(2'b10, HOLD); drive(2'b01, HOLD); drive(2'b10, HOLD);
    drive(2'b00, 4);
    drive(2'b10, HOLD);
    drive(2'b01, HOLD);
    for (int i = 0; i < MINC - 1; i++) drive((i % 2 == 0) ? 2'b10 : 2'b01, HOLD);
    chk("R6 repeated symbol restarts count", termSel, 1);
    drive(2'b01, DEB);
    chk("R6 hs after fresh full sequence", termSel, 0);
  endtask

  task automatic t_fallback();
    hardReset();
    busResetDet = 1'b1;
    repeat (5) @(negedge clk);
    busResetDet = 1'b0;
    @(negedge clk);
    chk("R8 fallback during delay", outs(), 6'b010001);
    hardReset();
    busResetDet = 1'b1;
    repeat (TD + 5) @(negedge clk);
    chk("R2 chirping before drop", txChirpReq, 1);
    busResetDet = 1'b0;
    @(negedge clk);
    chk("R8 fallback during own chirp", outs(), 6'b010001);
    hardReset();
    toHostCount();
    drive(2'b10, HOLD); drive(2'b01, HOLD);
    busResetDet = 1'b0;
    @(negedge clk);
    chk("R8 fallback during host count", outs(), 6'b010001);
    repeat (5) @(negedge clk);
    chk("R9 fallback holds", fsFallback, 1);
    busResetDet = 1'b1;
    @(negedge clk);
    chk("R9 new reset clears fallback", {fsFallback, opMode}, 3'b010);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_chirp_timing();
    t_good_sequence();
    t_squelch();
    t_ready_restart();
    t_short_run();
    t_bad_order();
    t_fallback();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule